// File: doc/BRIEF.md
# Sample Rate Ratio Detector

This block measures how fast an incoming audio word clock runs compared with the local output sample rate. The local system clock is taken to run at 512 times the output sample rate. The block counts system-clock cycles across a window of whole input word-clock periods. From that count it produces an unsigned fixed-point estimate of the output-to-input rate ratio. It also produces a 3-bit code that selects one of six anti-aliasing filter bands.

The word clock is asynchronous to the system clock, so a synchronizer and a rising-edge detector sit in front of the counter. The first rising edge seen after reset opens the first window. Each later window begins at the edge that closed the one before, so the windows run back to back. The ratio, the band code and a ready flag change only when a window closes.

After any break in either clock, the block must be reset again, because a count taken across a gap gives a wrong ratio. The window length is 2^LOG_PERIODS input periods. The default gives a resolution of one part in 65536 at a ratio of 1.

Top module: `rate_ratio_detector`

## Requirements
- R1: A rising edge of `word_clk` that is first sampled high at clock edge t, after being sampled low at edge t-1, is acted on at clock edge t+2. At most one window update follows from each rising edge.
- R2: When a window closes, `ratio` takes the value D·2^FRAC_BITS / (512·2^LOG_PERIODS). Here D is the number of clock edges between the edge that opened the window and the edge that closed it, and the result is an unsigned number with INT_BITS integer bits and FRAC_BITS fraction bits.
- R3: When a window closes, `mode` takes the band code for the new ratio r. The cut points are Ck = floor(32·2^FRAC_BITS/k). The code is 1 if r ≥ C33, 2 if C37 ≤ r < C33, 3 if C45 ≤ r < C37, 4 if C51 ≤ r < C45, 5 if C65 < r < C51, and 6 if r ≤ C65.
- R4: `ready` is 0 from reset until the first window closes and stays at 1 after that. The first rising edge after reset only opens a window and causes no update.
- R5: `ratio`, `mode` and `ready` change only at the clock edge that closes a window. The edge that closes a window also opens the next one.
- R6: The cycle count saturates at 2^(INT_BITS+FRAC_BITS+9+LOG_PERIODS-FRAC_BITS)-1. A window longer than that reports the saturated count, scaled as in R2, with `mode` equal to 1.
- R7: While `rst_n` is low, `ratio` is 0, `mode` is 0 and `ready` is 0. Reset discards any window that is open.
- R8: `mode` is 0 whenever `ready` is 0, and lies in 1..6 whenever `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 512 times the output sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Input word clock, asynchronous to clk |
| ratio | output | INT_BITS+FRAC_BITS | Measured output/input rate ratio, unsigned fixed point |
| mode | output | 3 | Filter band code, 1..6, 0 before ready |
| ready | output | 1 | A complete window has been measured since reset |

## Verification
The hardest cases to reach are ratios that sit one count either side of a band cut point, and the saturation of the cycle counter. To get there, the bench drives the word clock with an exact whole number of system-clock cycles per period, so each window's count can be known in advance. It then steps through pairs of periods whose scaled counts straddle each cut point. For saturation it uses one period long enough to overflow the counter. Period changes and a reset in the middle of a window create windows that mix two periods. A behavioural model follows these windows cycle by cycle.

// File: rtl/rrd_pkg.sv
package rrd_pkg;

   typedef logic [2:0] band_t;

   localparam band_t BAND_NONE = 3'd0;
   localparam int    NUM_CUTS  = 5;

   // denominators of the band cut points, highest cut first
   function automatic int cut_divisor(input int idx);
      case (idx)
         0:       return 33;
         1:       return 37;
         2:       return 45;
         3:       return 51;
         default: return 65;
      endcase
   endfunction

   // cut point as fixed point with frac fraction bits: floor(32 * 2^frac / k)
   function automatic longint unsigned cut_value(input int idx, input int frac);
      longint unsigned num;
      num = longint'(32) << frac;
      return num / longint'(cut_divisor(idx));
   endfunction

endpackage

// File: rtl/rrd_sync_edge.sv
module rrd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   localparam int DEPTH = STAGES + 1;

   logic [DEPTH-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rrd_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[DEPTH-2:0], async_in};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/rrd_window_counter.sv
module rrd_window_counter #(
   parameter int LOG_PERIODS = 7,
   parameter int CNT_W       = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic             win_end,
   output logic [CNT_W-1:0] span
);
   localparam int            PW   = (LOG_PERIODS > 0) ? LOG_PERIODS : 1;
   localparam logic [PW-1:0] LAST = PW'((2 ** LOG_PERIODS) - 1);

   logic             armed;
   logic [PW-1:0]    per_cnt;
   logic [CNT_W-1:0] cyc;

   assign win_end = rise & armed & (per_cnt == LAST);
   assign span    = cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         per_cnt <= '0;
         cyc     <= '0;
      end else if (!armed) begin
         if (rise) begin
            armed   <= 1'b1;
            per_cnt <= '0;
            cyc     <= CNT_W'(1);
         end
      end else begin
         if (win_end)     cyc <= CNT_W'(1);
         else if (!(&cyc)) cyc <= cyc + CNT_W'(1);
         if (rise) per_cnt <= win_end ? '0 : per_cnt + PW'(1);
      end
   end

endmodule

// File: rtl/rrd_band_classify.sv
module rrd_band_classify #(
   parameter int RW        = 18,
   parameter int FRAC_BITS = 16
) (
   input  logic [RW-1:0]      ratio,
   output rrd_pkg::band_t     band
);
   localparam int NC = rrd_pkg::NUM_CUTS;

   logic [NC-1:0] hit;

   generate
      for (genvar i = 0; i < NC; i++) begin : g_cut
         localparam logic [RW-1:0] CUT = RW'(rrd_pkg::cut_value(i, FRAC_BITS));
         if (i == NC - 1) begin : g_open
            assign hit[i] = ratio > CUT;
         end else begin : g_closed
            assign hit[i] = ratio >= CUT;
         end
      end
   endgenerate

   always_comb begin
      int n;
      n = 0;
      for (int i = 0; i < NC; i++) n += int'(hit[i]);
      band = rrd_pkg::band_t'(NC + 1 - n);
   end

endmodule

// File: rtl/rate_ratio_detector.sv
module rate_ratio_detector #(
   parameter int FRAC_BITS   = 16,
   parameter int INT_BITS    = 2,
   parameter int LOG_PERIODS = 7,
   parameter int OSR_LOG     = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          word_clk,
   output logic [INT_BITS+FRAC_BITS-1:0] ratio,
   output logic [2:0]                    mode,
   output logic                          ready
);
   localparam int RW    = INT_BITS + FRAC_BITS;
   localparam int SHIFT = OSR_LOG + LOG_PERIODS - FRAC_BITS;
   localparam int CNT_W = RW + SHIFT;

   generate
      if (FRAC_BITS < 8 || FRAC_BITS > 40) begin : g_bad_frac
         $error("rate_ratio_detector: FRAC_BITS out of range");
      end
      if (INT_BITS < 1) begin : g_bad_int
         $error("rate_ratio_detector: INT_BITS must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("rate_ratio_detector: window too short for FRAC_BITS");
      end
   endgenerate

   logic             rise;
   logic             win_end;
   logic [CNT_W-1:0] span;
   logic [RW-1:0]    scaled;
   rrd_pkg::band_t   band;

   rrd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (word_clk),
      .rise     (rise)
   );

   rrd_window_counter #(.LOG_PERIODS(LOG_PERIODS), .CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise),
      .win_end (win_end),
      .span    (span)
   );

   generate
      if (SHIFT >= 0) begin : g_shift_down
         assign scaled = span[CNT_W-1:SHIFT];
      end else begin : g_shift_up
         localparam int LSH = -SHIFT;
         assign scaled = {span, {LSH{1'b0}}};
      end
   endgenerate

   rrd_band_classify #(.RW(RW), .FRAC_BITS(FRAC_BITS)) u_band (
      .ratio (scaled),
      .band  (band)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio <= '0;
         mode  <= rrd_pkg::BAND_NONE;
         ready <= 1'b0;
      end else if (win_end) begin
         ratio <= scaled;
         mode  <= band;
         ready <= 1'b1;
      end
   end

endmodule

// File: rtl/rate_ratio_detector_chk.sv
module rate_ratio_detector_chk #(
   parameter int FRAC_BITS = 16,
   parameter int INT_BITS  = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [INT_BITS+FRAC_BITS-1:0] ratio,
   input logic [2:0]                    mode,
   input logic                          ready,
   input logic                          win_end
);
   localparam int            RW     = INT_BITS + FRAC_BITS;
   localparam logic [RW-1:0] LOWCUT = RW'(rrd_pkg::cut_value(4, FRAC_BITS));

   // R8
   mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> mode == 3'd0);

   // R8
   mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mode >= 3'd1 && mode <= 3'd6));

   // R4
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   // R5
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> ($stable(ratio) && $stable(mode) && $stable(ready)));

   // R5
   close_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> ready);

   // R3
   low_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && ratio <= LOWCUT) |-> mode == 3'd6);

endmodule

bind rate_ratio_detector rate_ratio_detector_chk #(
   .FRAC_BITS (FRAC_BITS),
   .INT_BITS  (INT_BITS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ratio   (ratio),
   .mode    (mode),
   .ready   (ready),
   .win_end (win_end)
);

// File: tb/tb_rate_ratio_detector.sv
`timescale 1ns/1ps
module tb_rate_ratio_detector;
   localparam int FB  = 16;
   localparam int IB  = 2;
   localparam int LP  = 2;
   localparam int RW  = FB + IB;
   localparam int NPER = 1 << LP;
   localparam int SATC = (1 << (RW + 9 + LP - FB)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          word_clk = 1'b0;
   logic [RW-1:0] ratio;
   logic [2:0]    mode;
   logic          ready;

   always #2.5 clk = ~clk;

   rate_ratio_detector #(.FRAC_BITS(FB), .INT_BITS(IB), .LOG_PERIODS(LP)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_clk (word_clk),
      .ratio    (ratio),
      .mode     (mode),
      .ready    (ready)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
      end
   endtask

   function automatic int ref_band(input longint r);
      longint c33, c37, c45, c51, c65;
      c33 = (longint'(32) << FB) / 33;
      c37 = (longint'(32) << FB) / 37;
      c45 = (longint'(32) << FB) / 45;
      c51 = (longint'(32) << FB) / 51;
      c65 = (longint'(32) << FB) / 65;
      if (r >= c33) return 1;
      if (r >= c37) return 2;
      if (r >= c45) return 3;
      if (r >= c51) return 4;
      if (r >  c65) return 5;
      return 6;
   endfunction

   // behavioural reference model
   int     seen[$];
   bit     started;
   longint elapsed;
   int     rises;
   longint e_ratio;
   int     e_mode;
   bit     e_ready;
   bit     pulse;
   longint capped;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen = '{0, 0, 0};
         started = 0; elapsed = 0; rises = 0;
         e_ratio = 0; e_mode = 0; e_ready = 0;
      end else begin
         seen.push_front(int'(word_clk));
         if (seen.size() > 4) void'(seen.pop_back());
         pulse = (seen[2] == 1) && (seen[3] == 0);
         if (pulse && !started) begin
            started = 1; elapsed = 1; rises = 0;
         end else if (started) begin
            if (pulse) rises++;
            if (pulse && rises == NPER) begin
               capped  = (elapsed > SATC) ? SATC : elapsed;
               e_ratio = (capped << FB) / (longint'(512) << LP);
               e_mode  = ref_band(e_ratio);
               e_ready = 1;
               elapsed = 1; rises = 0;
            end else begin
               elapsed++;
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         check(ready == e_ready, "R1 R4 ready", ready, e_ready);
         check(longint'(ratio) == e_ratio, "R2 R5 ratio", ratio, e_ratio);
         check(int'(mode) == e_mode, "R3 R8 mode", mode, e_mode);
      end
   end

   task automatic run_periods(input int p, input int n);
      for (int i = 0; i < n; i++) begin
         word_clk = 1'b1;
         repeat (p / 2) @(negedge clk);
         word_clk = 1'b0;
         repeat (p - p / 2) @(negedge clk);
      end
   endtask

   int plist[18] = '{512, 497, 496, 470, 443, 442, 372, 365, 364,
                     341, 322, 321, 256, 253, 252, 235, 1129, 2100};
   int mlist[18] = '{1, 1, 2, 2, 2, 3, 3, 3, 4,
                     4, 4, 5, 5, 5, 6, 6, 1, 1};

   initial begin
      repeat (5) @(negedge clk);
      check(ratio == '0 && mode == 3'd0 && ready == 1'b0, "R7 reset outputs", {ready, mode}, 0);
      @(negedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b0, "R4 not ready before a window", ready, 0);
      for (int k = 0; k < 18; k++) begin
         run_periods(plist[k], 12);
         check(int'(mode) == mlist[k], $sformatf("R3 band for period %0d", plist[k]), mode, mlist[k]);
         if (plist[k] == 1129)
            check(longint'(ratio) == 128 * 1129, "R2 ratio at top of range", ratio, 128 * 1129);
         if (plist[k] == 2100)
            check(longint'(ratio) == longint'(SATC) * 32, "R6 saturated ratio", ratio, longint'(SATC) * 32);
      end
      run_periods(512, 6);
      @(negedge clk); #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(ratio == '0 && mode == 3'd0 && ready == 1'b0, "R7 mid-run reset", {ready, mode}, 0);
      #1 rst_n = 1'b1;
      run_periods(512, 2);
      check(ready == 1'b0, "R7 partial window discarded", ready, 0);
      run_periods(512, 10);
      check(ready == 1'b1 && mode == 3'd1, "R4 ready after full window", {ready, mode}, 9);
      check(longint'(ratio) == 65536, "R2 unity ratio", ratio, 65536);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule